// File: doc/BRIEF.md
# Program Memory Lock Controller

This block keeps three sticky protection bits for an on-chip program flash and turns them into per-request permission signals. A bit moves only from clear to set when a program command names it. The one way back to clear is a chip-erase command, which wipes all three at once. The more bits are set, the more kinds of access are refused. The ladder is cumulative:
- The first bit stops code-table reads that come from external code from reaching internal bytes. It also stops flash writes.
- The second bit also stops flash verify reads.
- The third bit also stops execution from external program memory.

The block also keeps a latched copy of the external-code-select pin. While the hardware reset is held, this copy follows the pin. When the first bit is set, the block raises a fault whenever the latched copy and the live pin disagree. After power-on, and before any hardware reset, the latch holds a power-up value that is fixed by a parameter. A separate power-on input models the point at which the non-volatile bits are loaded. Hardware reset leaves the lock bits untouched.

Top module: `plock_ctrl`

## Requirements
- R1: Access request kinds use these codes: 1 = code-table read, 2 = flash write, 3 = flash verify, 4 = external execution. At most one grant is high at any time. Nothing is granted when `acc_valid` is low, or when the kind is 0, 5, 6 or 7.
- R2: With no lock bit set, every request of kinds 1 to 4 is granted, whatever the value of `acc_from_ext`.
- R3: A program command with `prog_idx` 0, 1 or 2 sets that bit from the next clock edge. Naming a bit that is already set changes nothing. Index 3 is ignored.
- R4: Set bits stay set. A chip erase clears all three bits in one edge, and it takes priority over a program command issued in the same cycle.
- R5: Program and erase commands issued while `rst_n` is low have no effect.
- R6: With bit 0 as the highest set bit, code-table reads with `acc_from_ext` high are refused. Code-table reads with `acc_from_ext` low, verify reads and external execution are still granted. Flash writes are refused.
- R7: With bit 1 as the highest set bit, verify reads are also refused.
- R8: With bit 2 set, external execution is also refused.
- R9: Any combination of set bits gives the protection level of the highest set bit, so bit 1 alone acts like bits 0 and 1 together.
- R10: The pin latch loads `EA_POR` when `por_n` is low. It copies `ea_pin` on every clock edge while `rst_n` is low, and holds its value otherwise.
- R11: `ea_fault` is high exactly when bit 0 is set and the latched pin value differs from `ea_pin`. It is low whenever bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on load, active low, asynchronous: bits take `LOCK_INIT`, the pin latch takes `EA_POR` |
| rst_n | input | 1 | Hardware reset, active low: the pin latch tracks the pin and commands are ignored |
| prog_req | input | 1 | Program one lock bit this cycle |
| prog_idx | input | 2 | Index of the bit to program |
| erase_req | input | 1 | Chip erase: clear all lock bits |
| ea_pin | input | 1 | Live external-code-select pin |
| acc_valid | input | 1 | An access request is present |
| acc_kind | input | 3 | Kind of request (codes in R1) |
| acc_from_ext | input | 1 | The code-table read comes from external code |
| grant_tbl | output | 1 | Code-table read granted |
| grant_wr | output | 1 | Flash write granted |
| grant_rd | output | 1 | Flash verify granted |
| grant_run | output | 1 | External execution granted |
| ea_fault | output | 1 | Latched pin value disagrees with the live pin while bit 0 is set |

## Verification
The bench programs bit 0 twice and targets index 3. A design that toggled bits or aliased the index would lose or gain protection. It issues erase and program in the same cycle. A design with the wrong priority would leave a bit set. It sets bit 1 alone, which a plain thermometer decode would treat as level 0, granting flash writes. It issues commands under hardware reset, and it pulses power-on without a hardware reset. A design that cleared bits on reset, obeyed commands during reset, or sampled the pin outside reset would show the wrong grants or the wrong fault level.

// File: rtl/plock_pkg.sv
package plock_pkg;

   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      ACC_IDLE     = 3'd0,
      ACC_TBL_RD   = 3'd1,
      ACC_FLASH_WR = 3'd2,
      ACC_FLASH_RD = 3'd3,
      ACC_EXT_RUN  = 3'd4
   } acc_kind_e;

   // protection level from which each access is refused
   localparam int LVL_BLOCK_XTBL = 1;
   localparam int LVL_BLOCK_WR   = 1;
   localparam int LVL_BLOCK_RD   = 2;
   localparam int LVL_BLOCK_RUN  = 3;

endpackage

// File: rtl/plock_store.sv
module plock_store #(
   parameter int                LOCK_W    = 3,
   parameter int                IDX_W     = 2,
   parameter logic [LOCK_W-1:0] LOCK_INIT = '0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              prog_req,
   input  logic [IDX_W-1:0]  prog_idx,
   input  logic              erase_req,
   output logic [LOCK_W-1:0] bits
);

   logic [LOCK_W-1:0] hit;
   logic [LOCK_W-1:0] bits_d;

   for (genvar g = 0; g < LOCK_W; g++) begin : g_hit
      assign hit[g] = prog_req && (prog_idx == IDX_W'(g));
   end

   // set-only update; erase wins; nothing moves under hardware reset
   always_comb begin
      bits_d = bits;
      if (rst_n) begin
         if (erase_req) bits_d = '0;
         else           bits_d = bits | hit;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) bits <= LOCK_INIT;
      else        bits <= bits_d;
   end

endmodule

// File: rtl/plock_level.sv
module plock_level #(
   parameter int LOCK_W = 3,
   parameter int LVL_W  = 2,
   parameter bit THERMO = 1'b0
) (
   input  logic [LOCK_W-1:0] bits,
   output logic [LVL_W-1:0]  lvl
);

   if (THERMO) begin : g_thermo
      // level counts only the unbroken run of set bits from bit 0
      always_comb begin
         logic run;
         lvl = '0;
         run = 1'b1;
         for (int i = 0; i < LOCK_W; i++) begin
            run = run & bits[i];
            if (run) lvl = LVL_W'(i + 1);
         end
      end
   end else begin : g_highest
      // level follows the highest set bit
      always_comb begin
         lvl = '0;
         for (int i = 0; i < LOCK_W; i++) begin
            if (bits[i]) lvl = LVL_W'(i + 1);
         end
      end
   end

endmodule

// File: rtl/plock_pin.sv
module plock_pin #(
   parameter bit EA_POR = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic ea_pin,
   input  logic lb_first,
   output logic ea_fault
);

   logic ea_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ea_q <= EA_POR;
      else if (!rst_n) ea_q <= ea_pin;
   end

   assign ea_fault = lb_first && (ea_q != ea_pin);

endmodule

// File: rtl/plock_gate.sv
module plock_gate
   import plock_pkg::*;
#(
   parameter int LVL_W = 2
) (
   input  logic [LVL_W-1:0]  lvl,
   input  logic              acc_valid,
   input  logic [KIND_W-1:0] acc_kind,
   input  logic              acc_from_ext,
   output logic              grant_tbl,
   output logic              grant_wr,
   output logic              grant_rd,
   output logic              grant_run
);

   localparam logic [LVL_W-1:0] TH_XTBL = LVL_W'(LVL_BLOCK_XTBL);
   localparam logic [LVL_W-1:0] TH_WR   = LVL_W'(LVL_BLOCK_WR);
   localparam logic [LVL_W-1:0] TH_RD   = LVL_W'(LVL_BLOCK_RD);
   localparam logic [LVL_W-1:0] TH_RUN  = LVL_W'(LVL_BLOCK_RUN);

   acc_kind_e kind;
   assign kind = acc_kind_e'(acc_kind);

   always_comb begin
      grant_tbl = 1'b0;
      grant_wr  = 1'b0;
      grant_rd  = 1'b0;
      grant_run = 1'b0;
      if (acc_valid) begin
         case (kind)
            ACC_TBL_RD:   grant_tbl = !acc_from_ext || (lvl < TH_XTBL);
            ACC_FLASH_WR: grant_wr  = lvl < TH_WR;
            ACC_FLASH_RD: grant_rd  = lvl < TH_RD;
            ACC_EXT_RUN:  grant_run = lvl < TH_RUN;
            default:      ;
         endcase
      end
   end

endmodule

// File: rtl/plock_ctrl.sv
module plock_ctrl
   import plock_pkg::*;
#(
   parameter int                LOCK_W        = 3,
   parameter logic [LOCK_W-1:0] LOCK_INIT     = '0,
   parameter bit                EA_POR        = 1'b0,
   parameter bit                THERMO_LADDER = 1'b0
) (
   input  logic                      clk,
   input  logic                      por_n,
   input  logic                      rst_n,
   input  logic                      prog_req,
   input  logic [$clog2(LOCK_W)-1:0] prog_idx,
   input  logic                      erase_req,
   input  logic                      ea_pin,
   input  logic                      acc_valid,
   input  logic [KIND_W-1:0]         acc_kind,
   input  logic                      acc_from_ext,
   output logic                      grant_tbl,
   output logic                      grant_wr,
   output logic                      grant_rd,
   output logic                      grant_run,
   output logic                      ea_fault
);

   localparam int IDX_W = $clog2(LOCK_W);
   localparam int LVL_W = $clog2(LOCK_W + 1);

   if (LOCK_W != 3) begin : g_bad_width
      $error("plock_ctrl: the protection ladder needs exactly three lock bits");
   end

   logic [LOCK_W-1:0] lock_bits;
   logic [LVL_W-1:0]  lvl;

   plock_store #(
      .LOCK_W    (LOCK_W),
      .IDX_W     (IDX_W),
      .LOCK_INIT (LOCK_INIT)
   ) u_store (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .prog_req  (prog_req),
      .prog_idx  (prog_idx),
      .erase_req (erase_req),
      .bits      (lock_bits)
   );

   plock_level #(
      .LOCK_W (LOCK_W),
      .LVL_W  (LVL_W),
      .THERMO (THERMO_LADDER)
   ) u_level (
      .bits (lock_bits),
      .lvl  (lvl)
   );

   plock_gate #(
      .LVL_W (LVL_W)
   ) u_gate (
      .lvl          (lvl),
      .acc_valid    (acc_valid),
      .acc_kind     (acc_kind),
      .acc_from_ext (acc_from_ext),
      .grant_tbl    (grant_tbl),
      .grant_wr     (grant_wr),
      .grant_rd     (grant_rd),
      .grant_run    (grant_run)
   );

   plock_pin #(
      .EA_POR (EA_POR)
   ) u_pin (
      .clk      (clk),
      .por_n    (por_n),
      .rst_n    (rst_n),
      .ea_pin   (ea_pin),
      .lb_first (lock_bits[0]),
      .ea_fault (ea_fault)
   );

endmodule

// File: rtl/plock_ctrl_chk.sv
module plock_ctrl_chk #(
   parameter int LOCK_W = 3
) (
   input logic                      clk,
   input logic                      por_n,
   input logic                      rst_n,
   input logic                      prog_req,
   input logic [$clog2(LOCK_W)-1:0] prog_idx,
   input logic                      erase_req,
   input logic [LOCK_W-1:0]         lock_bits,
   input logic                      grant_tbl,
   input logic                      grant_wr,
   input logic                      grant_rd,
   input logic                      grant_run,
   input logic                      ea_fault
);

   // R1
   one_grant_chk: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({grant_tbl, grant_wr, grant_rd, grant_run}));

   // R3
   prog_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
      (prog_req && rst_n && !erase_req && prog_idx == '0) |=> lock_bits[0]);

   // R4
   sticky_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(erase_req && rst_n) |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

   // R4
   erase_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
      (erase_req && rst_n) |=> (lock_bits == '0));

   // R5
   reset_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> $stable(lock_bits));

   // R6
   wr_open_chk: assert property (@(posedge clk) disable iff (!por_n)
      grant_wr |-> (lock_bits == '0));

   // R8
   run_closed_chk: assert property (@(posedge clk) disable iff (!por_n)
      grant_run |-> !lock_bits[LOCK_W-1]);

   // R11
   fault_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      ea_fault |-> lock_bits[0]);

endmodule

bind plock_ctrl plock_ctrl_chk #(
   .LOCK_W (LOCK_W)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .prog_req  (prog_req),
   .prog_idx  (prog_idx),
   .erase_req (erase_req),
   .lock_bits (lock_bits),
   .grant_tbl (grant_tbl),
   .grant_wr  (grant_wr),
   .grant_rd  (grant_rd),
   .grant_run (grant_run),
   .ea_fault  (ea_fault)
);

// File: tb/plock_ctrl_bench.sv
module plock_ctrl_bench;
   import plock_pkg::*;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       por_n, rst_n, prog_req, erase_req, ea_pin;
   logic       acc_valid, acc_from_ext;
   logic [1:0] prog_idx;
   logic [2:0] acc_kind;
   logic       grant_tbl, grant_wr, grant_rd, grant_run, ea_fault;

   plock_ctrl u_plock_ctrl (
      .clk          (clk),
      .por_n        (por_n),
      .rst_n        (rst_n),
      .prog_req     (prog_req),
      .prog_idx     (prog_idx),
      .erase_req    (erase_req),
      .ea_pin       (ea_pin),
      .acc_valid    (acc_valid),
      .acc_kind     (acc_kind),
      .acc_from_ext (acc_from_ext),
      .grant_tbl    (grant_tbl),
      .grant_wr     (grant_wr),
      .grant_rd     (grant_rd),
      .grant_run    (grant_run),
      .ea_fault     (ea_fault)
   );

   typedef struct {
      string      tag;
      logic [4:0] exp;
   } item_t;

   item_t      sb_q[$];
   item_t      mon_it;
   logic [4:0] mon_act;
   int         total = 0;
   int         bad   = 0;
   bit         done  = 1'b0;

   // bench-side view of the lock bits and the pin latch
   logic [2:0] lb_m;
   logic       lat_m;

   // expected {tbl, wr, rd, run, fault} from the requirements
   function automatic logic [4:0] model(input logic v, input logic [2:0] k, input logic x);
      int         lvl;
      logic [4:0] e;
      lvl = lb_m[2] ? 3 : lb_m[1] ? 2 : lb_m[0] ? 1 : 0;
      e = '0;
      if (v) begin
         if (k == 3'd1) e[4] = !x || (lvl < 1);
         if (k == 3'd2) e[3] = (lvl < 1);
         if (k == 3'd3) e[2] = (lvl < 2);
         if (k == 3'd4) e[1] = (lvl < 3);
      end
      e[0] = lb_m[0] && (lat_m != ea_pin);
      return e;
   endfunction

   // driver: apply a request, queue its expected result
   task automatic chk(input string tag, input logic v, input logic [2:0] k, input logic x);
      item_t it;
      acc_valid    = v;
      acc_kind     = k;
      acc_from_ext = x;
      it.tag = tag;
      it.exp = model(v, k, x);
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic prog(input logic [1:0] idx);
      prog_req = 1'b1;
      prog_idx = idx;
      @(negedge clk);
      prog_req = 1'b0;
   endtask

   task automatic erase();
      erase_req = 1'b1;
      @(negedge clk);
      erase_req = 1'b0;
   endtask

   // monitor: compare outputs with the queued expectation
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         #3;
         mon_it  = sb_q.pop_front();
         mon_act = {grant_tbl, grant_wr, grant_rd, grant_run, ea_fault};
         total++;
         if (mon_act !== mon_it.exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", mon_it.tag, mon_act, mon_it.exp);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      por_n = 1'b0; rst_n = 1'b0; prog_req = 1'b0; erase_req = 1'b0;
      prog_idx = 2'd0; ea_pin = 1'b1; acc_valid = 1'b0; acc_kind = 3'd0;
      acc_from_ext = 1'b0;
      lb_m = 3'b000; lat_m = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      lat_m = 1'b1;

      // reset state and request decoding
      chk("R1 no valid, table kind", 1'b0, 3'd1, 1'b1);
      chk("R1 no valid, run kind",   1'b0, 3'd4, 1'b0);
      chk("R1 kind 0",               1'b1, 3'd0, 1'b0);
      chk("R1 kind 6",               1'b1, 3'd6, 1'b1);
      chk("R2 ext table read",       1'b1, 3'd1, 1'b1);
      chk("R2 flash write",          1'b1, 3'd2, 1'b0);
      chk("R2 verify",               1'b1, 3'd3, 1'b0);
      chk("R2 ext run",              1'b1, 3'd4, 1'b0);

      // first level
      prog(2'd0); lb_m[0] = 1'b1;
      chk("R3 bit0 set, write refused", 1'b1, 3'd2, 1'b0);
      chk("R6 ext table read refused",  1'b1, 3'd1, 1'b1);
      chk("R6 int table read granted",  1'b1, 3'd1, 1'b0);
      chk("R6 verify still granted",    1'b1, 3'd3, 1'b0);
      chk("R6 run still granted",       1'b1, 3'd4, 1'b0);
      ea_pin = 1'b0;
      chk("R11 pin differs, fault",     1'b0, 3'd0, 1'b0);
      ea_pin = 1'b1;
      chk("R11 pin agrees, no fault",   1'b0, 3'd0, 1'b0);

      prog(2'd0);
      chk("R3 reprogram no-op verify",  1'b1, 3'd3, 1'b0);
      prog(2'd3);
      chk("R3 index 3 ignored verify",  1'b1, 3'd3, 1'b0);
      chk("R3 index 3 ignored run",     1'b1, 3'd4, 1'b0);

      prog(2'd1); lb_m[1] = 1'b1;
      chk("R7 verify refused",          1'b1, 3'd3, 1'b0);
      chk("R7 run granted",             1'b1, 3'd4, 1'b0);
      prog(2'd2); lb_m[2] = 1'b1;
      chk("R8 run refused",             1'b1, 3'd4, 1'b0);
      chk("R8 int table read granted",  1'b1, 3'd1, 1'b0);

      erase(); lb_m = 3'b000;
      chk("R4 erase, write granted",    1'b1, 3'd2, 1'b0);
      chk("R4 erase, run granted",      1'b1, 3'd4, 1'b0);

      // off-ladder combination
      prog(2'd1); lb_m = 3'b010;
      chk("R9 bit1 alone, write refused",   1'b1, 3'd2, 1'b0);
      chk("R9 bit1 alone, verify refused",  1'b1, 3'd3, 1'b0);
      chk("R9 bit1 alone, ext table refused", 1'b1, 3'd1, 1'b1);
      chk("R9 bit1 alone, run granted",     1'b1, 3'd4, 1'b0);
      ea_pin = 1'b0;
      chk("R11 bit0 clear, no fault",       1'b0, 3'd0, 1'b0);
      ea_pin = 1'b1;

      // erase and program in the same cycle
      erase_req = 1'b1; prog_req = 1'b1; prog_idx = 2'd2;
      @(negedge clk);
      erase_req = 1'b0; prog_req = 1'b0;
      lb_m = 3'b000;
      chk("R4 erase beats program, run", 1'b1, 3'd4, 1'b0);
      chk("R4 erase beats program, rd",  1'b1, 3'd3, 1'b0);

      // commands under hardware reset
      prog(2'd0); lb_m = 3'b001;
      rst_n = 1'b0; ea_pin = 1'b0;
      erase();
      prog(2'd2);
      rst_n = 1'b1; lat_m = 1'b0;
      chk("R5 program in reset ignored, run", 1'b1, 3'd4, 1'b0);
      chk("R5 erase in reset ignored, write", 1'b1, 3'd2, 1'b0);
      chk("R10 latch took 0, pin 0",          1'b0, 3'd0, 1'b0);
      ea_pin = 1'b1;
      chk("R10 latch held 0, pin 1",          1'b0, 3'd0, 1'b0);

      // power-on without hardware reset
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      lb_m = 3'b000; lat_m = 1'b0;
      chk("R10 power-on clears bits, write", 1'b1, 3'd2, 1'b0);
      prog(2'd0); lb_m = 3'b001;
      chk("R10 power-up latch, fault",       1'b0, 3'd0, 1'b0);
      ea_pin = 1'b0;
      chk("R11 power-up latch agrees",       1'b0, 3'd0, 1'b0);

      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule